// File: doc/BRIEF.md
# Operand Effective Address Generator

This block takes one decoded operand descriptor and works out where the operand lives. The descriptor carries a mode code, register selectors, up to two sign-extended displacements, a read/write direction, an operand size and an optional scaled-index request. The result is a memory address, a note that the operand is a general-purpose register, or an error flag when the combination cannot be encoded legally.

Most modes finish in the cycle after `start`. The two-level pointer mode and the link-table mode first need a pointer word from memory. For these the block raises a single-word read request and waits for the acknowledge. It then adds the second displacement, plus any scaled index, to the returned word. Top-of-stack operands also report the new value of the selected stack pointer, so that the register file can write it back.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (register) completes with `done` one cycle after the accepting edge, with `is_reg`=1, `reg_num`=`reg_sel`, `ea`=0 and no memory read.
- R2: Mode code 1 (register relative) gives `ea` = GPR[`reg_sel`] + `disp0` one cycle after acceptance.
- R3: Mode code 2 (dedicated base) gives `ea` = base + `disp0`, where `base_sel` 0 picks PC, 1 the selected stack pointer (`sp_sel`=0 SP0, 1 SP1), 2 SB and 3 FP.
- R4: Mode code 3 (two-level pointer) reads the word at base + `disp0`, with the base chosen by `base_sel` as in R3, and gives `ea` = that word + `disp1`. `base_sel`=0 is illegal.
- R5: Mode code 6 (link table) reads the word at `link_base` + 4·`disp0` and gives `ea` = that word + `disp1`.
- R6: Mode code 4 (immediate) completes with `ea`=0, `is_reg`=0 and no read when `is_write`=0. It raises `err` when `is_write`=1.
- R7: Mode code 5 (absolute) gives `ea` = `disp0`.
- R8: Mode code 7 (top of stack) uses the selected stack pointer. The size step is 1, 2 or 4 bytes for `op_size` codes 0, 1 and 2. A write gives `ea` = SP − step and reports that same value as the new SP. A read gives `ea` = SP and reports SP + step. `sp_upd_valid` pulses with `done`, and `sp_upd_which` = `sp_sel`. `op_size`=3 is illegal.
- R9: With `idx_en`=1, GPR[`idx_reg`]·2^`idx_scale` is added to the final address of modes 1, 2, 3, 5, 6 and 7. For modes 3 and 6 it is added after the pointer fetch.
- R10: Errors come from `idx_en` on base modes 0, 4 or 8, from mode code 8 or above, and from the cases in R4, R6 and R8. An error completes one cycle after acceptance with `err`=1, `ea`=0, `is_reg`=0, no read and no stack update.
- R11: During a fetch, `rd_req` stays high with `rd_addr` unchanged until `rd_ack` is sampled. `done` follows in the next cycle, with `rd_data` taken in the acknowledge cycle.
- R12: `start` is ignored while a fetch is outstanding, including in the acknowledge cycle.
- R13: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a descriptor when idle |
| mode | input | 4 | Addressing-mode code |
| base_sel | input | 2 | Dedicated base: 0 PC, 1 SP, 2 SB, 3 FP |
| reg_sel | input | 3 | General-purpose register selector |
| disp0 | input | 32 | First displacement or link entry index, sign-extended |
| disp1 | input | 32 | Second displacement, sign-extended |
| is_write | input | 1 | Operand is a destination |
| op_size | input | 2 | Operand size code (0:1, 1:2, 2:4 bytes) |
| idx_en | input | 1 | Scaled-index option present |
| idx_reg | input | 3 | Index register selector |
| idx_scale | input | 2 | Index scale exponent (×1/2/4/8) |
| gpr_flat | input | 256 | Eight general-purpose registers, register i at bits 32i+31:32i |
| pc | input | 32 | Program counter |
| sp0 | input | 32 | Stack pointer 0 |
| sp1 | input | 32 | Stack pointer 1 |
| sp_sel | input | 1 | Selected stack pointer |
| sb | input | 32 | Static base |
| fp | input | 32 | Frame pointer |
| link_base | input | 32 | Current link table base |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 32 | Pointer read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 32 | Effective address |
| is_reg | output | 1 | Operand is a register |
| reg_num | output | 3 | Register number when `is_reg` |
| err | output | 1 | Illegal combination |
| sp_upd_valid | output | 1 | Stack pointer update valid |
| sp_upd_which | output | 1 | Which stack pointer to update |
| sp_upd_value | output | 32 | New stack pointer value |

## Verification
Two events can land on the same edge: the acknowledge that ends a pointer fetch, and a fresh `start` that would open a new descriptor. The bench raises `start` together with `rd_ack`, and also while the read is still waiting. It then expects the old operation's address from the returned word and `disp1`. It also expects no new read request and no second `done` in the cycle after. The scaled-index add also coincides with the stack-pointer step in top-of-stack mode. In that case both `ea` and `sp_upd_value` are checked against independent arithmetic in the bench.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    MD_REG  = 4'd0,
    MD_RREL = 4'd1,
    MD_DEDI = 4'd2,
    MD_PTR2 = 4'd3,
    MD_IMM  = 4'd4,
    MD_ABS  = 4'd5,
    MD_LINK = 4'd6,
    MD_STK  = 4'd7,
    MD_XIDX = 4'd8
  } ea_mode_e;

  typedef enum logic [1:0] {
    BS_PC = 2'd0,
    BS_SP = 2'd1,
    BS_SB = 2'd2,
    BS_FP = 2'd3
  } base_sel_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ea_state_e;

endpackage

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [NREG*AW-1:0] gpr_flat,
  input  logic               idx_en,
  input  logic [RW-1:0]      idx_reg,
  input  logic [1:0]         idx_scale,
  output logic [AW-1:0]      idx_off
);

  function automatic logic [AW-1:0] scale_reg(logic [AW-1:0] r, logic [1:0] s);
    return r << s;
  endfunction

  logic [AW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_unpack
    assign regs[i] = gpr_flat[i*AW +: AW];
  end

  assign idx_off = idx_en ? scale_reg(regs[idx_reg], idx_scale) : '0;

endmodule

// File: rtl/ea_stack_adjust.sv
module ea_stack_adjust #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] sp_cur,
  input  logic          push,
  input  logic [1:0]    size_code,
  output logic [AW-1:0] tos_addr,
  output logic [AW-1:0] sp_next,
  output logic          size_bad
);

  function automatic logic [AW-1:0] step_bytes(logic [1:0] c);
    return AW'(1) << c;
  endfunction

  logic [AW-1:0] step;

  assign step     = step_bytes(size_code);
  assign size_bad = (size_code == 2'd3);

  always_comb begin
    if (push) begin
      sp_next  = sp_cur - step;
      tos_addr = sp_next;
    end else begin
      tos_addr = sp_cur;
      sp_next  = sp_cur + step;
    end
  end

endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [3:0]         mode,
  input  logic [1:0]         base_sel,
  input  logic [RW-1:0]      reg_sel,
  input  logic [AW-1:0]      disp0,
  input  logic [AW-1:0]      disp1,
  input  logic               is_write,
  input  logic [1:0]         op_size,
  input  logic               idx_en,
  input  logic [NREG*AW-1:0] gpr_flat,
  input  logic [AW-1:0]      pc,
  input  logic [AW-1:0]      sp_cur,
  input  logic [AW-1:0]      sb,
  input  logic [AW-1:0]      fp,
  input  logic [AW-1:0]      link_base,
  input  logic [AW-1:0]      idx_off,
  output logic               ill,
  output logic               need_rd,
  output logic [AW-1:0]      ptr_addr,
  output logic [AW-1:0]      post_add,
  output logic [AW-1:0]      direct_ea,
  output logic               reg_op,
  output logic               sp_upd,
  output logic [AW-1:0]      sp_next
);

  function automatic logic [AW-1:0] link_entry(logic [AW-1:0] lb, logic [AW-1:0] ix);
    return lb + (ix << 2);
  endfunction

  logic [AW-1:0] regs [NREG];
  logic [AW-1:0] ded_base;
  logic [AW-1:0] tos_addr;
  logic [AW-1:0] dir_base;
  logic          size_bad;
  logic          idx_bad;
  logic          mode_ill;

  for (genvar i = 0; i < NREG; i++) begin : g_unpack
    assign regs[i] = gpr_flat[i*AW +: AW];
  end

  always_comb begin
    case (base_sel)
      BS_PC:   ded_base = pc;
      BS_SP:   ded_base = sp_cur;
      BS_SB:   ded_base = sb;
      default: ded_base = fp;
    endcase
  end

  ea_stack_adjust #(.AW(AW)) u_stk (
    .sp_cur   (sp_cur),
    .push     (is_write),
    .size_code(op_size),
    .tos_addr (tos_addr),
    .sp_next  (sp_next),
    .size_bad (size_bad)
  );

  assign idx_bad = idx_en && (mode == MD_REG || mode == MD_IMM || mode == MD_XIDX);

  always_comb begin
    mode_ill = 1'b0;
    need_rd  = 1'b0;
    reg_op   = 1'b0;
    sp_upd   = 1'b0;
    ptr_addr = '0;
    dir_base = '0;
    case (mode)
      MD_REG:  reg_op = 1'b1;
      MD_RREL: dir_base = regs[reg_sel] + disp0;
      MD_DEDI: dir_base = ded_base + disp0;
      MD_PTR2: begin
        need_rd  = 1'b1;
        ptr_addr = ded_base + disp0;
        mode_ill = (base_sel == BS_PC);
      end
      MD_IMM:  mode_ill = is_write;
      MD_ABS:  dir_base = disp0;
      MD_LINK: begin
        need_rd  = 1'b1;
        ptr_addr = link_entry(link_base, disp0);
      end
      MD_STK: begin
        dir_base = tos_addr;
        sp_upd   = 1'b1;
        mode_ill = size_bad;
      end
      default: mode_ill = 1'b1;
    endcase
  end

  assign ill       = mode_ill || idx_bad;
  assign direct_ea = dir_base + idx_off;
  assign post_add  = disp1 + idx_off;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [3:0]         mode,
  input  logic [1:0]         base_sel,
  input  logic [RW-1:0]      reg_sel,
  input  logic [AW-1:0]      disp0,
  input  logic [AW-1:0]      disp1,
  input  logic               is_write,
  input  logic [1:0]         op_size,
  input  logic               idx_en,
  input  logic [RW-1:0]      idx_reg,
  input  logic [1:0]         idx_scale,
  input  logic [NREG*AW-1:0] gpr_flat,
  input  logic [AW-1:0]      pc,
  input  logic [AW-1:0]      sp0,
  input  logic [AW-1:0]      sp1,
  input  logic               sp_sel,
  input  logic [AW-1:0]      sb,
  input  logic [AW-1:0]      fp,
  input  logic [AW-1:0]      link_base,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_ack,
  input  logic [AW-1:0]      rd_data,
  output logic               done,
  output logic [AW-1:0]      ea,
  output logic               is_reg,
  output logic [RW-1:0]      reg_num,
  output logic               err,
  output logic               sp_upd_valid,
  output logic               sp_upd_which,
  output logic [AW-1:0]      sp_upd_value
);

  ea_state_e     st;
  logic [AW-1:0] sp_cur;
  logic [AW-1:0] idx_off;
  logic          ill, need_rd, reg_op, sp_upd;
  logic [AW-1:0] ptr_addr, post_add, direct_ea, sp_next;
  logic [AW-1:0] rd_addr_q, post_q;

  // named events for the assertions
  logic accept_w;
  logic fetch_done_w;

  assign sp_cur       = sp_sel ? sp1 : sp0;
  assign accept_w     = start && (st == ST_IDLE);
  assign fetch_done_w = (st == ST_FETCH) && rd_ack;

  ea_index_scaler #(.AW(AW), .NREG(NREG)) u_idx (
    .gpr_flat (gpr_flat),
    .idx_en   (idx_en),
    .idx_reg  (idx_reg),
    .idx_scale(idx_scale),
    .idx_off  (idx_off)
  );

  ea_mode_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .mode     (mode),
    .base_sel (base_sel),
    .reg_sel  (reg_sel),
    .disp0    (disp0),
    .disp1    (disp1),
    .is_write (is_write),
    .op_size  (op_size),
    .idx_en   (idx_en),
    .gpr_flat (gpr_flat),
    .pc       (pc),
    .sp_cur   (sp_cur),
    .sb       (sb),
    .fp       (fp),
    .link_base(link_base),
    .idx_off  (idx_off),
    .ill      (ill),
    .need_rd  (need_rd),
    .ptr_addr (ptr_addr),
    .post_add (post_add),
    .direct_ea(direct_ea),
    .reg_op   (reg_op),
    .sp_upd   (sp_upd),
    .sp_next  (sp_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      rd_addr_q    <= '0;
      post_q       <= '0;
      done         <= 1'b0;
      ea           <= '0;
      is_reg       <= 1'b0;
      reg_num      <= '0;
      err          <= 1'b0;
      sp_upd_valid <= 1'b0;
      sp_upd_which <= 1'b0;
      sp_upd_value <= '0;
    end else begin
      done         <= 1'b0;
      sp_upd_valid <= 1'b0;
      if (accept_w) begin
        if (ill) begin
          done    <= 1'b1;
          err     <= 1'b1;
          ea      <= '0;
          is_reg  <= 1'b0;
          reg_num <= '0;
        end else if (need_rd) begin
          st        <= ST_FETCH;
          rd_addr_q <= ptr_addr;
          post_q    <= post_add;
        end else begin
          done         <= 1'b1;
          err          <= 1'b0;
          ea           <= reg_op ? '0 : direct_ea;
          is_reg       <= reg_op;
          reg_num      <= reg_op ? reg_sel : '0;
          sp_upd_valid <= sp_upd;
          sp_upd_which <= sp_sel;
          sp_upd_value <= sp_next;
        end
      end else if (fetch_done_w) begin
        st      <= ST_IDLE;
        done    <= 1'b1;
        err     <= 1'b0;
        ea      <= rd_data + post_q;
        is_reg  <= 1'b0;
        reg_num <= '0;
      end
    end
  end

  assign rd_req  = (st == ST_FETCH);
  assign rd_addr = rd_addr_q;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> done && !rd_req);

  a_r12_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !done);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> !sp_upd_valid && !is_reg && ea == '0);

  a_r1_reg_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_reg |-> ea == '0 && !sp_upd_valid);

  a_r8_upd_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    sp_upd_valid |-> done);

endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  base_sel = '0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] disp0 = '0, disp1 = '0;
  logic        is_write = 1'b0;
  logic [1:0]  op_size = '0;
  logic        idx_en = 1'b0;
  logic [2:0]  idx_reg = '0;
  logic [1:0]  idx_scale = '0;
  logic [255:0] gpr_flat;
  logic [31:0] pc, sp0, sp1, sb, fp, link_base;
  logic        sp_sel = 1'b0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        done, is_reg, err, sp_upd_valid, sp_upd_which;
  logic [31:0] ea, sp_upd_value;
  logic [2:0]  reg_num;

  logic [31:0] gr [8];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = gr[i];

  ea_gen u0 (.*);

  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected-result model
  logic        e_err, e_rd, e_isreg, e_spv;
  logic [31:0] e_ptr, e_ea, e_spval;
  logic [2:0]  e_rn;

  task automatic model(int md, int bs, int rs, logic [31:0] d0, logic [31:0] d1,
                       bit wr, int sz, bit ie, int ir, int isc, bit ss);
    longint base, xo, sp, stepb;
    sp = ss ? sp1 : sp0;
    case (bs)
      0: base = pc; 1: base = sp; 2: base = sb; default: base = fp;
    endcase
    xo = ie ? longint'(gr[ir]) * (longint'(1) << isc) : 0;
    stepb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    e_err = 0; e_rd = 0; e_isreg = 0; e_spv = 0; e_ptr = 0; e_ea = 0; e_spval = 0; e_rn = 0;
    if (ie && (md == 0 || md == 4 || md == 8)) e_err = 1;
    case (md)
      0: begin e_isreg = 1; e_rn = rs[2:0]; end
      1: e_ea = 32'(longint'(gr[rs]) + longint'(signed'(d0)) + xo);
      2: e_ea = 32'(base + longint'(signed'(d0)) + xo);
      3: begin
        if (bs == 0) e_err = 1;
        e_rd = 1; e_ptr = 32'(base + longint'(signed'(d0)));
        e_ea = 32'(longint'(memf(e_ptr)) + longint'(signed'(d1)) + xo);
      end
      4: if (wr) e_err = 1;
      5: e_ea = 32'(longint'(d0) + xo);
      6: begin
        e_rd = 1; e_ptr = 32'(longint'(link_base) + 4 * longint'(d0));
        e_ea = 32'(longint'(memf(e_ptr)) + longint'(signed'(d1)) + xo);
      end
      7: begin
        if (sz == 3) e_err = 1;
        e_spv = 1;
        e_spval = wr ? 32'(sp - stepb) : 32'(sp + stepb);
        e_ea = 32'((wr ? sp - stepb : sp) + xo);
      end
      default: e_err = 1;
    endcase
    if (e_err) begin e_rd = 0; e_isreg = 0; e_spv = 0; e_ea = 0; e_rn = 0; end
  endtask

  task automatic op(string tag, int md, int bs, int rs, logic [31:0] d0, logic [31:0] d1,
                    bit wr, int sz, bit ie, int ir, int isc, bit ss, int lat, bit clash);
    model(md, bs, rs, d0, d1, wr, sz, ie, ir, isc, ss);
    @(negedge clk);
    mode = 4'(md); base_sel = 2'(bs); reg_sel = 3'(rs); disp0 = d0; disp1 = d1;
    is_write = wr; op_size = 2'(sz); idx_en = ie; idx_reg = 3'(ir); idx_scale = 2'(isc);
    sp_sel = ss; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tag, "rd_req", {31'd0, rd_req}, {31'd0, e_rd});
    if (e_rd) begin
      chk(tag, "rd_addr", rd_addr, e_ptr);
      chk(tag, "done during fetch", {31'd0, done}, 32'd0);
      for (int k = 0; k < lat; k++) begin
        if (clash) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "rd_req held", {31'd0, rd_req}, 32'd1);
        chk("R11", "rd_addr held", rd_addr, e_ptr);
      end
      rd_ack = 1'b1; rd_data = memf(rd_addr);
      if (clash) begin start = 1'b1; mode = 4'd5; idx_en = 1'b0; end
      @(negedge clk);
      rd_ack = 1'b0; rd_data = '0; start = 1'b0;
    end
    chk(tag, "done", {31'd0, done}, 32'd1);
    chk(tag, "err", {31'd0, err}, {31'd0, e_err});
    chk(tag, "ea", ea, e_ea);
    chk(tag, "is_reg", {31'd0, is_reg}, {31'd0, e_isreg});
    chk(tag, "reg_num", {29'd0, reg_num}, {29'd0, e_rn});
    chk(tag, "sp_upd_valid", {31'd0, sp_upd_valid}, {31'd0, e_spv});
    if (e_spv) begin
      chk(tag, "sp_upd_value", sp_upd_value, e_spval);
      chk(tag, "sp_upd_which", {31'd0, sp_upd_which}, {31'd0, ss});
    end
    @(negedge clk);
    chk("R13", "done pulse", {31'd0, done}, 32'd0);
    if (clash) chk("R12", "no new fetch", {31'd0, rd_req}, 32'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) gr[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0110;
    pc = 32'h0000_4000; sp0 = 32'h0000_8000; sp1 = 32'h0000_9000;
    sb = 32'h0002_0000; fp = 32'h0003_0000; link_base = 32'h0005_0000;
    repeat (3) @(negedge clk);
    chk("RST", "done", {31'd0, done}, 32'd0);
    chk("RST", "rd_req", {31'd0, rd_req}, 32'd0);
    chk("RST", "sp_upd_valid", {31'd0, sp_upd_valid}, 32'd0);
    rst_n = 1'b1;

    op("R1", 0, 0, 5, 32'd0, 32'd0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R2", 1, 0, 3, 32'hFFFF_FFC0, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R2", 1, 0, 7, 32'd8191, 0, 1, 2, 0, 0, 0, 0, 0, 0);
    op("R3", 2, 0, 0, 32'd63, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R3", 2, 1, 0, 32'hFFFF_E000, 0, 0, 2, 0, 0, 0, 1, 0, 0);
    op("R3", 2, 2, 0, 32'd12, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R3", 2, 3, 0, 32'hFFFF_FFF8, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R4", 3, 2, 0, 32'd16, 32'd4, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R4", 3, 3, 0, 32'hFFFF_FFF0, 32'hFFFF_FFC0, 0, 2, 0, 0, 0, 0, 3, 0);
    op("R4", 3, 1, 0, 32'd4, 32'd1, 0, 2, 0, 0, 0, 1, 1, 0);
    op("R4", 3, 0, 0, 32'd4, 32'd1, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R5", 6, 0, 0, 32'd9, 32'd2, 0, 2, 0, 0, 0, 0, 2, 0);
    op("R6", 4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    op("R6", 4, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    op("R7", 5, 0, 0, 32'h00AB_CD00, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R8", 7, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    op("R8", 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    op("R8", 7, 0, 0, 0, 0, 1, 2, 0, 0, 0, 1, 0, 0);
    op("R8", 7, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    op("R9", 1, 0, 2, 32'd100, 0, 0, 2, 1, 6, 3, 0, 0, 0);
    op("R9", 2, 2, 0, 32'd4, 0, 0, 2, 1, 1, 1, 0, 0, 0);
    op("R9", 5, 0, 0, 32'h40, 0, 0, 2, 1, 4, 0, 0, 0, 0);
    op("R9", 3, 3, 0, 32'd8, 32'd3, 0, 2, 1, 3, 2, 0, 1, 0);
    op("R9", 6, 0, 0, 32'd1, 32'd0, 0, 2, 1, 7, 3, 0, 0, 0);
    op("R9", 7, 0, 0, 0, 0, 1, 2, 1, 2, 2, 1, 0, 0);
    op("R10", 4, 0, 0, 0, 0, 0, 2, 1, 1, 1, 0, 0, 0);
    op("R10", 0, 0, 1, 0, 0, 0, 2, 1, 1, 1, 0, 0, 0);
    op("R10", 8, 0, 0, 0, 0, 0, 2, 1, 1, 1, 0, 0, 0);
    op("R10", 8, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R10", 12, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    op("R12", 3, 2, 0, 32'd32, 32'd5, 0, 2, 0, 0, 0, 0, 2, 1);
    op("R12", 6, 0, 0, 32'd3, 32'hFFFF_FFFC, 0, 2, 1, 5, 1, 0, 0, 1);
    op("R2", 1, 0, 0, 32'd1, 0, 0, 2, 0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule